// File: doc/BRIEF.md
# Accumulator Processor Control Sequencer

This block is the control core of a small accumulator machine that keeps its program and its data in one memory with one address space. Every instruction goes through an explicit chain of register transfers. The program counter is copied into the memory address register and then advanced by one. The word that comes back from memory is captured in the memory data register and then moved into the current instruction register. That register is split into an opcode and an operand, and the instruction is carried out. The sequencer then goes back to the start of the chain.

The memory port is synchronous and single-ported. The read data for an address appears one clock after the address is presented. A write takes effect at the clock edge where the write enable is high. Arithmetic results always go to the accumulator. Comparisons set an equality flag, and conditional jumps test that flag. An index register offsets the indexed load. On the last execute state of every instruction, a one-cycle strobe gives an interrupt unit a defined sampling point.

States and transitions:

| State | Action | Next state |
| --- | --- | --- |
| ST_F_MAR | MAR takes PC, PC takes PC+1 | ST_F_READ |
| ST_F_READ | the memory reads at MAR | ST_F_MDR |
| ST_F_MDR | MDR takes the read data | ST_F_CIR |
| ST_F_CIR | CIR takes MDR | ST_DECODE |
| ST_DECODE | the opcode is classified | ST_X_MAR for memory operations, otherwise ST_X_RUN |
| ST_X_MAR | MAR takes the effective address | ST_X_WRITE for a store, otherwise ST_X_READ |
| ST_X_READ | the memory reads at MAR | ST_X_MDR |
| ST_X_MDR | MDR takes the read data | ST_X_RUN |
| ST_X_RUN | the instruction is executed and the strobe is raised | ST_F_MAR |
| ST_X_WRITE | ACC is written to memory and the strobe is raised | ST_F_MAR |

Top module: `acc_seq_core`

## Requirements
- R1: While reset is low, and in the first cycle after it, PC, ACC and all three flags read zero, and mem_we and cycle_end are low.
- R2: An instruction starts in the cycle after the previous one ends. In the cycle after that start, mem_addr shows the old PC and pc_value already shows the old PC plus one.
- R3: A data load can read any word of the memory, including words that hold code. Loading address 0 returns the instruction word stored there.
- R4: The instruction word has the opcode in bits 15:12 and the operand in bits 11:0. The opcodes are: 0 no-op, 1 load immediate, 2 load direct, 3 load indexed, 4 store, 5 add direct, 6 add immediate, 7 compare direct, 8 compare immediate, 9 jump, A jump if equal, B jump if not equal, C load index immediate, D increment index. An immediate operand is zero-extended to 16 bits.
- R5: Add direct and add immediate write the 16-bit sum to ACC. They set the carry flag to the carry out of bit 15.
- R6: A load indexed reads the address operand+IX, taken modulo 4096.
- R7: A store raises mem_we for exactly one cycle. In that cycle mem_addr holds the operand and mem_wdata holds ACC.
- R8: A compare sets the equality flag to (ACC == value) and leaves ACC unchanged. Jump if equal loads PC with the operand only when the flag is 1. Jump if not equal does so only when the flag is 0.
- R9: A jump loads PC with the operand with no test.
- R10: Opcodes E and F set the error flag, which stays set until reset. They change neither ACC nor the flow of the program.
- R11: cycle_end is a single-cycle pulse, once per instruction. Register-only instructions take 6 cycles, stores take 7 and memory reads take 9.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Memory address (the MAR) |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| mem_wdata | output | 16 | Write data (the ACC) |
| mem_we | output | 1 | Write enable |
| cycle_end | output | 1 | End-of-instruction strobe for interrupt sampling |
| acc_value | output | 16 | Current accumulator |
| pc_value | output | 12 | Current program counter |
| flag_eq | output | 1 | Equality flag from the last compare |
| flag_carry | output | 1 | Carry flag from the last add |
| flag_err | output | 1 | Sticky undefined-opcode flag |

## Verification
The hardest cases to reach from the ports are the ones where a flag set by one instruction decides the path of a later one. Examples are a taken jump on equal after a matching compare, and a jump on equal that falls through after a mismatching compare. The undefined opcode must also be shown to leave ACC and the program order alone. The bench reaches these cases with a single program in its memory model. In that program, skipped instructions would produce stores the scoreboard does not expect. The same program loads its own first code word back as data and reuses a word that an earlier store wrote.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

    localparam int OP_W = 4;

    typedef enum logic [3:0] {
        ST_F_MAR,
        ST_F_READ,
        ST_F_MDR,
        ST_F_CIR,
        ST_DECODE,
        ST_X_MAR,
        ST_X_READ,
        ST_X_MDR,
        ST_X_RUN,
        ST_X_WRITE
    } state_t;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 4'h0,
        OP_LDI  = 4'h1,
        OP_LDD  = 4'h2,
        OP_LDX  = 4'h3,
        OP_STO  = 4'h4,
        OP_ADD  = 4'h5,
        OP_ADDI = 4'h6,
        OP_CMP  = 4'h7,
        OP_CMPI = 4'h8,
        OP_JMP  = 4'h9,
        OP_JEQ  = 4'hA,
        OP_JNE  = 4'hB,
        OP_SETX = 4'hC,
        OP_INCX = 4'hD
    } opcode_t;

    typedef enum logic [1:0] {
        K_REG,
        K_MEMRD,
        K_MEMWR
    } op_kind_t;

endpackage

// File: rtl/acc_seq_decode.sv
module acc_seq_decode
    import acc_seq_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output op_kind_t        kind,
    output logic            indexed,
    output logic            legal
);
    always_comb begin
        kind    = K_REG;
        indexed = 1'b0;
        legal   = 1'b1;
        case (opcode)
            OP_LDD, OP_ADD, OP_CMP: kind = K_MEMRD;
            OP_LDX: begin
                kind    = K_MEMRD;
                indexed = 1'b1;
            end
            OP_STO: kind = K_MEMWR;
            OP_NOP, OP_LDI, OP_ADDI, OP_CMPI,
            OP_JMP, OP_JEQ, OP_JNE, OP_SETX, OP_INCX: kind = K_REG;
            default: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] sum,
    output logic              carry,
    output logic              equal
);
    logic [DATA_W:0] wide;

    always_comb begin
        wide  = {1'b0, acc} + {1'b0, src};
        sum   = wide[DATA_W-1:0];
        carry = wide[DATA_W];
        equal = (acc == src);
    end
endmodule

// File: rtl/acc_seq_fsm.sv
module acc_seq_fsm
    import acc_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  op_kind_t kind,
    output state_t   state,
    output logic     ld_fetch,
    output logic     ld_mdr,
    output logic     ld_cir,
    output logic     ld_ea,
    output logic     run,
    output logic     wr,
    output logic     done
);
    state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_F_MAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_F_MAR:   state_d = ST_F_READ;
            ST_F_READ:  state_d = ST_F_MDR;
            ST_F_MDR:   state_d = ST_F_CIR;
            ST_F_CIR:   state_d = ST_DECODE;
            ST_DECODE:  state_d = (kind == K_REG) ? ST_X_RUN : ST_X_MAR;
            ST_X_MAR:   state_d = (kind == K_MEMWR) ? ST_X_WRITE : ST_X_READ;
            ST_X_READ:  state_d = ST_X_MDR;
            ST_X_MDR:   state_d = ST_X_RUN;
            ST_X_RUN:   state_d = ST_F_MAR;
            ST_X_WRITE: state_d = ST_F_MAR;
            default:    state_d = ST_F_MAR;
        endcase
    end

    always_comb begin
        ld_fetch = 1'b0;
        ld_mdr   = 1'b0;
        ld_cir   = 1'b0;
        ld_ea    = 1'b0;
        run      = 1'b0;
        wr       = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_F_MAR:   ld_fetch = 1'b1;
            ST_F_MDR,
            ST_X_MDR:   ld_mdr = 1'b1;
            ST_F_CIR:   ld_cir = 1'b1;
            ST_X_MAR:   ld_ea = 1'b1;
            ST_X_RUN: begin
                run  = 1'b1;
                done = 1'b1;
            end
            ST_X_WRITE: begin
                wr   = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
    import acc_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              cycle_end,
    output logic [DATA_W-1:0] acc_value,
    output logic [ADDR_W-1:0] pc_value,
    output logic              flag_eq,
    output logic              flag_carry,
    output logic              flag_err
);
    localparam int PAD_W = DATA_W - ADDR_W;

    logic [ADDR_W-1:0] pc_q, mar_q, ix_q;
    logic [DATA_W-1:0] mdr_q, cir_q, acc_q;
    logic              eq_q, carry_q, err_q;

    logic [OP_W-1:0]   opcode;
    logic [ADDR_W-1:0] operand, ea;
    logic [DATA_W-1:0] src, sum;
    logic              carry, equal, indexed, legal;
    logic              ld_fetch, ld_mdr, ld_cir, ld_ea, run, wr, done;
    op_kind_t          kind;
    state_t            state;

    assign opcode  = cir_q[DATA_W-1 -: OP_W];
    assign operand = cir_q[ADDR_W-1:0];
    assign ea      = indexed ? (operand + ix_q) : operand;
    assign src     = (kind == K_MEMRD) ? mdr_q : {{PAD_W{1'b0}}, operand};

    acc_seq_decode u_dec (
        .opcode  (opcode),
        .kind    (kind),
        .indexed (indexed),
        .legal   (legal)
    );

    acc_seq_alu #(.DATA_W(DATA_W)) u_alu (
        .acc   (acc_q),
        .src   (src),
        .sum   (sum),
        .carry (carry),
        .equal (equal)
    );

    acc_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .state    (state),
        .ld_fetch (ld_fetch),
        .ld_mdr   (ld_mdr),
        .ld_cir   (ld_cir),
        .ld_ea    (ld_ea),
        .run      (run),
        .wr       (wr),
        .done     (done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            mar_q   <= '0;
            ix_q    <= '0;
            mdr_q   <= '0;
            cir_q   <= '0;
            acc_q   <= '0;
            eq_q    <= 1'b0;
            carry_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (ld_fetch) begin
                mar_q <= pc_q;
                pc_q  <= pc_q + 1'b1;
            end
            if (ld_mdr) mdr_q <= mem_rdata;
            if (ld_cir) cir_q <= mdr_q;
            if (ld_ea)  mar_q <= ea;
            if (run) begin
                if (!legal) begin
                    err_q <= 1'b1;
                end else begin
                    case (opcode_t'(opcode))
                        OP_LDI, OP_LDD, OP_LDX: acc_q <= src;
                        OP_ADD, OP_ADDI: begin
                            acc_q   <= sum;
                            carry_q <= carry;
                        end
                        OP_CMP, OP_CMPI: eq_q <= equal;
                        OP_JMP: pc_q <= operand;
                        OP_JEQ: if (eq_q)  pc_q <= operand;
                        OP_JNE: if (!eq_q) pc_q <= operand;
                        OP_SETX: ix_q <= operand;
                        OP_INCX: ix_q <= ix_q + 1'b1;
                        default: ;
                    endcase
                end
            end
        end
    end

    assign mem_addr   = mar_q;
    assign mem_wdata  = acc_q;
    assign mem_we     = wr;
    assign cycle_end  = done;
    assign acc_value  = acc_q;
    assign pc_value   = pc_q;
    assign flag_eq    = eq_q;
    assign flag_carry = carry_q;
    assign flag_err   = err_q;
endmodule

// File: rtl/acc_seq_core_chk.sv
module acc_seq_core_chk
    import acc_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input state_t            state,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] pc_value,
    input logic              mem_we,
    input logic              cycle_end,
    input logic              flag_err,
    input logic [DATA_W-1:0] acc_value
);
    p_mar_gets_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_F_MAR) |=> (mem_addr == $past(pc_value)));

    p_pc_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_F_MAR) |=> (pc_value == $past(pc_value) + 1'b1));

    p_we_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    p_we_in_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> cycle_end);

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_err |=> flag_err);

    p_end_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end |=> !cycle_end);

    p_store_keeps_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> $stable(acc_value));
endmodule

bind acc_seq_core acc_seq_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .mem_addr  (mem_addr),
    .pc_value  (pc_value),
    .mem_we    (mem_we),
    .cycle_end (cycle_end),
    .flag_err  (flag_err),
    .acc_value (acc_value)
);

// File: tb/acc_seq_core_tb.sv
module acc_seq_core_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic [15:0] mem_rdata;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic        cycle_end;
    logic [15:0] acc_value;
    logic [11:0] pc_value;
    logic        flag_eq, flag_carry, flag_err;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [15:0] mem [256];
    logic [27:0] exp_wr [$];
    int          gaps [$];
    int          cyc = 0;
    int          last_end = 0;
    bit          prev_end = 0;
    int          pulse_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_seq_core u_dut (
        .clk(clk), .rst_n(rst_n),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we),
        .cycle_end(cycle_end), .acc_value(acc_value), .pc_value(pc_value),
        .flag_eq(flag_eq), .flag_carry(flag_carry), .flag_err(flag_err)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[7:0]];
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_store(logic [11:0] a, logic [15:0] d);
        exp_wr.push_back({a, d});
    endtask

    task automatic run_instr();
        do @(negedge clk); while (!cycle_end);
        @(negedge clk);
    endtask

    // Monitor: scoreboard for stores (R7) and strobe spacing (R11)
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (cycle_end && prev_end) pulse_bad++;
            prev_end = cycle_end;
            if (cycle_end) begin
                gaps.push_back(cyc - last_end);
                last_end = cyc;
            end
            if (mem_we) begin
                if (exp_wr.size() == 0) begin
                    checks++;
                    failures++;
                    $display("FAIL R7 unexpected store actual=%h/%h expected=none",
                             mem_addr, mem_wdata);
                end else begin
                    logic [27:0] e;
                    e = exp_wr.pop_front();
                    check("R7 store", {mem_addr, mem_wdata}, e);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        mem[8'h00] = 16'h1005; // load imm 5
        mem[8'h01] = 16'h6003; // add imm 3
        mem[8'h02] = 16'h4080; // store 80
        mem[8'h03] = 16'h2081; // load 81
        mem[8'h04] = 16'h5082; // add 82
        mem[8'h05] = 16'h4083; // store 83
        mem[8'h06] = 16'hC002; // ix = 2
        mem[8'h07] = 16'h3084; // load 84+ix
        mem[8'h08] = 16'h4085; // store 85
        mem[8'h09] = 16'h7086; // compare 86
        mem[8'h0A] = 16'hA00D; // jump eq 0D
        mem[8'h0B] = 16'h1BAD; // skipped
        mem[8'h0C] = 16'h4087; // skipped
        mem[8'h0D] = 16'h8001; // compare imm 1
        mem[8'h0E] = 16'hA00B; // jump eq (falls through)
        mem[8'h0F] = 16'hB011; // jump ne 11
        mem[8'h10] = 16'h4088; // skipped
        mem[8'h11] = 16'hE000; // undefined
        mem[8'h12] = 16'h2000; // load code word at 0
        mem[8'h13] = 16'h4089; // store 89
        mem[8'h14] = 16'hD000; // ix++
        mem[8'h15] = 16'h3080; // load 80+3
        mem[8'h16] = 16'h408A; // store 8A
        mem[8'h17] = 16'h9017; // jump to self
        mem[8'h81] = 16'hFFFF;
        mem[8'h82] = 16'h0002;
        mem[8'h86] = 16'h1234;

        push_store(12'h080, 16'h0008);
        push_store(12'h083, 16'h0001);
        push_store(12'h085, 16'h1234);
        push_store(12'h089, 16'h1005);
        push_store(12'h08A, 16'h0001);

        repeat (3) @(negedge clk);
        check("R1 pc", pc_value, 0);
        check("R1 acc", acc_value, 0);
        check("R1 flags", {flag_eq, flag_carry, flag_err}, 0);
        check("R1 we/end", {mem_we, cycle_end}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 mar=old pc", mem_addr, 12'h000);
        check("R2 pc+1", pc_value, 12'h001);
        check("R1 acc after reset", acc_value, 0);

        run_instr(); check("R4 load imm", acc_value, 16'h0005);
        run_instr(); check("R5 add imm", acc_value, 16'h0008);
        check("R5 no carry", flag_carry, 0);
        run_instr();                                   // store 80
        run_instr(); check("R4 load direct", acc_value, 16'hFFFF);
        run_instr(); check("R5 add wrap", acc_value, 16'h0001);
        check("R5 carry", flag_carry, 1);
        run_instr();                                   // store 83
        run_instr();                                   // ix = 2
        run_instr(); check("R6 indexed", acc_value, 16'h1234);
        run_instr();                                   // store 85
        run_instr(); check("R8 eq set", flag_eq, 1);
        check("R8 acc kept", acc_value, 16'h1234);
        run_instr(); check("R8 jeq taken", pc_value, 12'h00D);
        run_instr(); check("R8 eq clear", flag_eq, 0);
        run_instr(); check("R8 jeq not taken", pc_value, 12'h00F);
        run_instr(); check("R8 jne taken", pc_value, 12'h011);
        run_instr(); check("R10 err", flag_err, 1);
        check("R10 acc kept", acc_value, 16'h1234);
        check("R10 flow kept", pc_value, 12'h012);
        run_instr(); check("R3 code as data", acc_value, 16'h1005);
        run_instr();                                   // store 89
        run_instr();                                   // ix = 3
        run_instr(); check("R6 indexed after inc", acc_value, 16'h0001);
        run_instr();                                   // store 8A
        run_instr(); check("R9 jump", pc_value, 12'h017);
        repeat (3) run_instr();
        check("R9 loop", pc_value, 12'h017);
        check("R10 err sticky", flag_err, 1);
        check("R7 all stores seen", exp_wr.size(), 0);
        check("R11 gap imm", gaps[1], 6);
        check("R11 gap store", gaps[2], 7);
        check("R11 gap mem read", gaps[3], 9);
        check("R11 single-cycle pulse", pulse_bad, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule